// File: doc/BRIEF.md
# Filtered Model-Specific Register File

This block is a bank of model-specific registers selected by a 32-bit index. A write takes its 64-bit value from two 32-bit input halves, with the upper half above the lower half. A read splits the selected 64-bit value back into two 32-bit outputs. The read path is combinational from the index. Writes happen on a rising clock edge while the write strobe is high.

The bank holds five kinds of state. The first is an extended-feature register whose bits can be written only when a matching feature-enable input is set. The second is eight variable-range memory-type base/mask pairs, and the third is eleven fixed-range memory-type slots. The fourth is a machine-check group: a read-only capability word, a global control word and per-bank registers. The last is a code-segment selector register that keeps only 16 bits. Every register applies its own write filter. A read of an index that matches nothing returns zero, and a write to such an index is dropped without any other effect.

Top module: `msr_file`

## Requirements
- R1: A write stores `{wr_hi, wr_lo}` as the 64-bit value. A read returns bits 31:0 on `rd_lo` and bits 63:32 on `rd_hi`.
- R2: Extended-feature register (index 0x8000_0001). Each bit of `feat_en` gates one register bit: `feat_en[0]` gates bit 0, `[1]` gates bit 8, `[2]` gates bit 14, `[3]` gates bit 11 and `[4]` gates bit 12. A gated bit takes the written value. Every other bit keeps its previous value.
- R3: Variable-range registers start at index 0x200. An even offset selects the base of pair offset/2 and an odd offset selects the mask of that pair, for 8 pairs (0x200..0x20F).
- R4: Fixed-range slots: index 0x250 is slot 0, indices 0x258..0x259 are slots 1..2, and indices 0x268..0x26F are slots 3..10. Each slot stores an independent 64-bit value.
- R5: Global machine-check control (index 0x21) is writable only when capability bit 8 is set, and only with the value 0 or all ones. When capability bit 8 is clear, it reads as 0.
- R6: Bank registers occupy indices 0x100 up to, but not including, 0x100 + 4·N. N is capability bits 7:0, capped at the MAX_BANKS parameter. Indices beyond that range are unknown.
- R7: A bank register whose offset from 0x100 is a multiple of 4 accepts only 0 or all ones. Bank registers at other offsets accept any value.
- R8: The code-segment register (index 0x10) keeps only bits 15:0 of a write and reads zero above bit 15.
- R9: The performance-status index (0x11) always reads 64'h0000_0400_0000_03E8, which is 1000 with 4 at bit 40. Writes to it are ignored.
- R10: Reads of unknown indices return 0, and writes to them change no register.
- R11: Reset clears every writable register to 0. The capability word (index 0x20) reads the MC_CAP parameter and ignores writes.
- R12: A write changes the read-back only after the clock edge. In the cycle the strobe is high, a read of the same index still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| idx | input | 32 | Register index for both read and write |
| wr_en | input | 1 | Write strobe |
| wr_lo | input | 32 | Write data bits 31:0 |
| wr_hi | input | 32 | Write data bits 63:32 |
| feat_en | input | 5 | Feature-present inputs gating extended-feature bits |
| rd_lo | output | 32 | Read data bits 31:0 |
| rd_hi | output | 32 | Read data bits 63:32 |

## Verification
The combinational read and the clocked write share the one index, so both act on the same register in the same cycle. The bench holds the strobe high with new data and samples the read outputs before the edge, where they must still show the previous value. It samples again after the edge, where they must show the filtered new value. The random phase hits this overlap on every write and mixes in the extreme values 0 and all ones, which exercises the acceptance filters. Expected values come from a bench-side model of every register.

// File: rtl/msr_pkg.sv
package msr_pkg;

  localparam int QW    = 64;
  localparam int HW    = 32;
  localparam int IW    = 32;
  localparam int NFEAT = 5;
  localparam int NFIX16 = 2;
  localparam int NFIX4  = 8;

  typedef logic [QW-1:0] qword_t;
  typedef logic [IW-1:0] index_t;

  // Index map
  localparam index_t IDX_SYSCS = 32'h0000_0010;
  localparam index_t IDX_PERF  = 32'h0000_0011;
  localparam index_t IDX_MCCAP = 32'h0000_0020;
  localparam index_t IDX_MCCTL = 32'h0000_0021;
  localparam index_t IDX_BANK0 = 32'h0000_0100;
  localparam index_t IDX_VAR0  = 32'h0000_0200;
  localparam index_t IDX_FIX64 = 32'h0000_0250;
  localparam index_t IDX_FIX16 = 32'h0000_0258;
  localparam index_t IDX_FIX4  = 32'h0000_0268;
  localparam index_t IDX_FEAT  = 32'h8000_0001;

  localparam qword_t PERF_CONST = 64'd1000 | (64'd4 << 40);

  // Register bit controlled by feat_en[k]
  localparam int FEAT_POS [NFEAT] = '{0, 8, 14, 11, 12};

  // Capability word fields
  localparam int CAP_CTL_BIT = 8;
  localparam int CAP_CNT_W   = 8;

  function automatic qword_t feat_mask(input logic [NFEAT-1:0] en);
    qword_t m;
    m = '0;
    for (int k = 0; k < NFEAT; k++) m[FEAT_POS[k]] = en[k];
    return m;
  endfunction

  function automatic qword_t join_halves(input logic [HW-1:0] lo, input logic [HW-1:0] hi);
    return {hi, lo};
  endfunction

  function automatic logic is_extreme(input qword_t v);
    return (v == '0) || (&v);
  endfunction

endpackage

// File: rtl/msr_feat_reg.sv
module msr_feat_reg
  import msr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  qword_t           wdata,
  input  logic [NFEAT-1:0] feat_en,
  output qword_t           q
);

  qword_t upd_mask;
  assign upd_mask = feat_mask(feat_en);

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= (q & ~upd_mask) | (wdata & upd_mask);
  end

  // R2: bits not enabled by a feature never move
  a_r2_locked_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (((q ^ $past(q)) & ~$past(upd_mask)) == '0));

  a_r12_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(q));

endmodule

// File: rtl/msr_range_file.sv
module msr_range_file
  import msr_pkg::*;
#(
  parameter int NUM_VAR = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  index_t idx,
  input  logic   wr_en,
  input  qword_t wdata,
  output logic   hit,
  output qword_t rdata
);

  localparam int     NUM_FIX  = 1 + NFIX16 + NFIX4;
  localparam int     PW       = (NUM_VAR > 1) ? $clog2(NUM_VAR) : 1;
  localparam int     SW       = $clog2(NUM_FIX);
  localparam index_t VAR_SPAN = IW'(2 * NUM_VAR);

  qword_t var_base [NUM_VAR];
  qword_t var_mask [NUM_VAR];
  qword_t fix_q    [NUM_FIX];

  index_t          var_off, off16, off4;
  logic            var_hit, fix_hit, is_mask;
  logic [PW-1:0]   pair;
  logic [SW-1:0]   slot;
  logic [NUM_VAR-1:0] base_we, mask_we;
  logic [NUM_FIX-1:0] fix_we;

  assign var_off = idx - IDX_VAR0;
  assign var_hit = var_off < VAR_SPAN;
  assign is_mask = var_off[0];
  assign pair    = var_off[PW:1];
  assign off16   = idx - IDX_FIX16;
  assign off4    = idx - IDX_FIX4;

  always_comb begin
    fix_hit = 1'b1;
    slot    = '0;
    if (idx == IDX_FIX64)          slot = '0;
    else if (off16 < IW'(NFIX16))  slot = SW'(1) + SW'(off16);
    else if (off4 < IW'(NFIX4))    slot = SW'(1 + NFIX16) + SW'(off4);
    else                           fix_hit = 1'b0;
  end

  for (genvar p = 0; p < NUM_VAR; p++) begin : g_var
    assign base_we[p] = wr_en & var_hit & ~is_mask & (pair == PW'(p));
    assign mask_we[p] = wr_en & var_hit &  is_mask & (pair == PW'(p));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        var_base[p] <= '0;
        var_mask[p] <= '0;
      end else begin
        if (base_we[p]) var_base[p] <= wdata;
        if (mask_we[p]) var_mask[p] <= wdata;
      end
    end
  end

  for (genvar s = 0; s < NUM_FIX; s++) begin : g_fix
    assign fix_we[s] = wr_en & fix_hit & (slot == SW'(s));
    always_ff @(posedge clk) begin
      if (!rst_n)         fix_q[s] <= '0;
      else if (fix_we[s]) fix_q[s] <= wdata;
    end
  end

  assign hit = var_hit | fix_hit;

  always_comb begin
    if (var_hit)      rdata = is_mask ? var_mask[pair] : var_base[pair];
    else if (fix_hit) rdata = fix_q[slot];
    else              rdata = '0;
  end

  // R3/R4: one index never lands in two storage slots
  a_r3_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({base_we, mask_we, fix_we}));

  a_r4_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
    fix_hit |-> (int'(slot) < NUM_FIX));

endmodule

// File: rtl/msr_mc_unit.sv
module msr_mc_unit
  import msr_pkg::*;
#(
  parameter qword_t MC_CAP    = 64'h0000_0000_0000_0104,
  parameter int     MAX_BANKS = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  index_t idx,
  input  logic   wr_en,
  input  qword_t wdata,
  output logic   hit,
  output qword_t rdata
);

  localparam int     NREGS    = 4 * MAX_BANKS;
  localparam int     BW       = $clog2(NREGS);
  localparam int     CAP_CNT  = int'(MC_CAP[CAP_CNT_W-1:0]);
  localparam int     EFF_CNT  = (CAP_CNT > MAX_BANKS) ? MAX_BANKS : CAP_CNT;
  localparam index_t LIMIT    = IW'(4 * EFF_CNT);
  localparam logic   CTL_PRES = MC_CAP[CAP_CTL_BIT];

  qword_t ctl_q;
  qword_t bank_q [NREGS];

  index_t        bank_off;
  logic          bank_hit, cap_hit, ctl_hit, ctl_accept;
  logic [BW-1:0] bank_sel;
  logic [NREGS-1:0] bank_accept;

  assign bank_off = idx - IDX_BANK0;
  assign bank_hit = bank_off < LIMIT;
  assign bank_sel = bank_off[BW-1:0];
  assign cap_hit  = idx == IDX_MCCAP;
  assign ctl_hit  = idx == IDX_MCCTL;

  assign ctl_accept = wr_en & ctl_hit & CTL_PRES & is_extreme(wdata);

  always_ff @(posedge clk) begin
    if (!rst_n)          ctl_q <= '0;
    else if (ctl_accept) ctl_q <= wdata;
  end

  for (genvar b = 0; b < NREGS; b++) begin : g_bank
    if ((b % 4) == 0) begin : g_strict
      assign bank_accept[b] = wr_en & bank_hit & (bank_sel == BW'(b)) & is_extreme(wdata);
      // R7: control-type bank entries only ever hold 0 or all ones
      a_r7_bank_extreme: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q[b] != $past(bank_q[b])) |-> is_extreme(bank_q[b]));
    end else begin : g_free
      assign bank_accept[b] = wr_en & bank_hit & (bank_sel == BW'(b));
    end
    always_ff @(posedge clk) begin
      if (!rst_n)              bank_q[b] <= '0;
      else if (bank_accept[b]) bank_q[b] <= wdata;
    end
  end

  assign hit = bank_hit | cap_hit | ctl_hit;

  always_comb begin
    if (cap_hit)       rdata = MC_CAP;
    else if (ctl_hit)  rdata = CTL_PRES ? ctl_q : '0;
    else if (bank_hit) rdata = bank_q[bank_sel];
    else               rdata = '0;
  end

  a_r5_ctl_extreme: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q != $past(ctl_q)) |-> is_extreme(ctl_q));

  a_r5_ctl_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_hit && !CTL_PRES) |-> (rdata == '0));

  a_r6_bank_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_accept != '0) |-> (bank_off < LIMIT));

endmodule

// File: rtl/msr_file.sv
module msr_file
  import msr_pkg::*;
#(
  parameter int     NUM_VAR   = 8,
  parameter int     MAX_BANKS = 4,
  parameter qword_t MC_CAP    = 64'h0000_0000_0000_0104
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IW-1:0]    idx,
  input  logic             wr_en,
  input  logic [HW-1:0]    wr_lo,
  input  logic [HW-1:0]    wr_hi,
  input  logic [NFEAT-1:0] feat_en,
  output logic [HW-1:0]    rd_lo,
  output logic [HW-1:0]    rd_hi
);

  localparam int CSW = 16;

  qword_t          wdata, feat_q, range_rd, mc_rd, rdata;
  logic            feat_hit, syscs_hit, perf_hit, range_hit, mc_hit, any_hit;
  logic [CSW-1:0]  syscs_q;

  assign wdata     = join_halves(wr_lo, wr_hi);
  assign feat_hit  = idx == IDX_FEAT;
  assign syscs_hit = idx == IDX_SYSCS;
  assign perf_hit  = idx == IDX_PERF;

  msr_feat_reg u_feat (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (wr_en & feat_hit),
    .wdata   (wdata),
    .feat_en (feat_en),
    .q       (feat_q)
  );

  msr_range_file #(.NUM_VAR(NUM_VAR)) u_range (
    .clk   (clk),
    .rst_n (rst_n),
    .idx   (idx),
    .wr_en (wr_en),
    .wdata (wdata),
    .hit   (range_hit),
    .rdata (range_rd)
  );

  msr_mc_unit #(.MC_CAP(MC_CAP), .MAX_BANKS(MAX_BANKS)) u_mc (
    .clk   (clk),
    .rst_n (rst_n),
    .idx   (idx),
    .wr_en (wr_en),
    .wdata (wdata),
    .hit   (mc_hit),
    .rdata (mc_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                  syscs_q <= '0;
    else if (wr_en && syscs_hit) syscs_q <= wdata[CSW-1:0];
  end

  assign any_hit = feat_hit | syscs_hit | perf_hit | range_hit | mc_hit;

  always_comb begin
    if (feat_hit)       rdata = feat_q;
    else if (syscs_hit) rdata = {{(QW-CSW){1'b0}}, syscs_q};
    else if (perf_hit)  rdata = PERF_CONST;
    else if (range_hit) rdata = range_rd;
    else if (mc_hit)    rdata = mc_rd;
    else                rdata = '0;
  end

  assign rd_lo = rdata[HW-1:0];
  assign rd_hi = rdata[QW-1:HW];

  a_r8_syscs_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    syscs_hit |-> (rd_hi == '0 && rd_lo[HW-1:CSW] == '0));

  a_r10_unknown_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !any_hit |-> ({rd_hi, rd_lo} == '0));

  // R12: without a write strobe and with the index held, read-back cannot move
  a_r12_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(idx) -> $stable({rd_hi, rd_lo})));

endmodule

// File: tb/test_msr_file.sv
module test_msr_file;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] idx = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_lo = '0, wr_hi = '0;
  logic [4:0]  feat_en = '0;
  logic [31:0] rd_lo, rd_hi, nc_lo, nc_hi;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  msr_file i_msr_file (
    .clk(clk), .rst_n(rst_n), .idx(idx), .wr_en(wr_en), .wr_lo(wr_lo),
    .wr_hi(wr_hi), .feat_en(feat_en), .rd_lo(rd_lo), .rd_hi(rd_hi));

  // Second copy: 2 banks, global control absent
  msr_file #(.MC_CAP(64'h0000_0000_0000_0002)) i_msr_file_nocap (
    .clk(clk), .rst_n(rst_n), .idx(idx), .wr_en(wr_en), .wr_lo(wr_lo),
    .wr_hi(wr_hi), .feat_en(feat_en), .rd_lo(nc_lo), .rd_hi(nc_hi));

  localparam logic [63:0] CAP   = 64'h0000_0000_0000_0104;
  localparam logic [63:0] PERF  = 64'h0000_0400_0000_03E8;
  localparam logic [63:0] ONES  = {64{1'b1}};
  localparam logic [31:0] A_FEAT = 32'h8000_0001, A_CS = 32'h10, A_PERF = 32'h11,
                          A_CAP = 32'h20, A_CTL = 32'h21, A_BANK = 32'h100,
                          A_VAR = 32'h200, A_F64 = 32'h250, A_F16 = 32'h258, A_F4 = 32'h268;

  // Bench-side model
  logic [63:0] m_feat, m_ctl;
  logic [15:0] m_cs;
  logic [63:0] m_base [8];
  logic [63:0] m_mask [8];
  logic [63:0] m_fix  [11];
  logic [63:0] m_bank [16];

  function automatic int fix_slot(input logic [31:0] a);
    if (a == A_F64) return 0;
    if (a == A_F16 || a == A_F16 + 1) return 1 + int'(a - A_F16);
    if (a >= A_F4 && a < A_F4 + 8) return 3 + int'(a - A_F4);
    return -1;
  endfunction

  function automatic logic [63:0] exp_read(input logic [31:0] a);
    if (a == A_FEAT) return m_feat;
    if (a == A_CS)   return {48'h0, m_cs};
    if (a == A_PERF) return PERF;
    if (a == A_CAP)  return CAP;
    if (a == A_CTL)  return m_ctl;
    if (a >= A_VAR && a < A_VAR + 16)
      return (a[0]) ? m_mask[(a - A_VAR) / 2] : m_base[(a - A_VAR) / 2];
    if (fix_slot(a) >= 0) return m_fix[fix_slot(a)];
    if (a >= A_BANK && a < A_BANK + 16) return m_bank[a - A_BANK];
    return 64'h0;
  endfunction

  function automatic logic ext(input logic [63:0] v);
    return (v == 64'h0) || (v == ONES);
  endfunction

  task automatic m_write(input logic [31:0] a, input logic [63:0] v, input logic [4:0] en);
    logic [63:0] mk;
    mk = 64'h0;
    if (en[0]) mk[0] = 1'b1;
    if (en[1]) mk[8] = 1'b1;
    if (en[2]) mk[14] = 1'b1;
    if (en[3]) mk[11] = 1'b1;
    if (en[4]) mk[12] = 1'b1;
    if (a == A_FEAT) m_feat = (m_feat & ~mk) | (v & mk);
    else if (a == A_CS) m_cs = v[15:0];
    else if (a == A_CTL) begin if (ext(v)) m_ctl = v; end
    else if (a >= A_VAR && a < A_VAR + 16) begin
      if (a[0]) m_mask[(a - A_VAR) / 2] = v; else m_base[(a - A_VAR) / 2] = v;
    end
    else if (fix_slot(a) >= 0) m_fix[fix_slot(a)] = v;
    else if (a >= A_BANK && a < A_BANK + 16) begin
      if (((a - A_BANK) % 4) != 0 || ext(v)) m_bank[a - A_BANK] = v;
    end
  endtask

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] a, input logic [63:0] v, input logic [4:0] en);
    @(negedge clk);
    idx = a; wr_lo = v[31:0]; wr_hi = v[63:32]; feat_en = en; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
    m_write(a, v, en);
  endtask

  task automatic read_check(input logic [31:0] a, input string tag);
    @(negedge clk);
    idx = a; wr_en = 1'b0;
    #1 check(tag, {rd_hi, rd_lo}, exp_read(a));
  endtask

  function automatic string tag_of(input logic [31:0] a);
    if (a == A_FEAT) return "R2";
    if (a == A_CS) return "R8";
    if (a == A_CTL) return "R5";
    if (a >= A_VAR && a < A_VAR + 16) return "R3";
    if (fix_slot(a) >= 0) return "R4";
    if (a >= A_BANK && a < A_BANK + 16) return "R7";
    return "R10";
  endfunction

  function automatic logic [31:0] pick_idx(input int unsigned r, input int unsigned s);
    case (r % 9)
      0: return A_FEAT;
      1: return A_CS;
      2: return A_VAR + (s % 16);
      3: return A_F64;
      4: return A_F16 + (s % 2);
      5: return A_F4 + (s % 8);
      6: return A_CTL;
      7: return A_BANK + (s % 16);
      default: return (s % 3 == 0) ? A_VAR + 16 : (s % 3 == 1) ? A_BANK + 16 : 32'h300 + (s % 64);
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] v;
    void'($urandom(32'd20240611));
    m_feat = 0; m_ctl = 0; m_cs = 0;
    for (int i = 0; i < 8; i++) begin m_base[i] = 0; m_mask[i] = 0; end
    for (int i = 0; i < 11; i++) m_fix[i] = 0;
    for (int i = 0; i < 16; i++) m_bank[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R11 reset state and capability
    read_check(A_FEAT, "R11 feat reset");
    read_check(A_VAR + 3, "R11 var reset");
    read_check(A_BANK + 5, "R11 bank reset");
    read_check(A_CAP, "R11 cap");
    do_write(A_CAP, 64'h1234, 5'h1f);
    read_check(A_CAP, "R11 cap write ignored");

    // R1 halves
    do_write(A_VAR + 6, 64'hCAFE_F00D_1357_9BDF, 5'h0);
    read_check(A_VAR + 6, "R1 halves");

    // R2 feature gating
    do_write(A_FEAT, ONES, 5'b00000);
    read_check(A_FEAT, "R2 none enabled");
    do_write(A_FEAT, ONES, 5'b00001);
    read_check(A_FEAT, "R2 bit0 only");
    do_write(A_FEAT, 64'h0, 5'b01000);
    read_check(A_FEAT, "R2 other bit kept");
    do_write(A_FEAT, ONES, 5'b11111);
    read_check(A_FEAT, "R2 all enabled");

    // R3 base/mask alternation
    do_write(A_VAR + 4, 64'h1111_0000_0000_0004, 5'h0);
    do_write(A_VAR + 5, 64'h2222_0000_0000_0005, 5'h0);
    read_check(A_VAR + 4, "R3 base pair2");
    read_check(A_VAR + 5, "R3 mask pair2");

    // R4 fixed slots
    do_write(A_F16 + 1, 64'hAAAA_0000_0000_0002, 5'h0);
    do_write(A_F4, 64'hBBBB_0000_0000_0003, 5'h0);
    read_check(A_F16 + 1, "R4 slot2");
    read_check(A_F4, "R4 slot3");
    read_check(A_F64, "R4 slot0 untouched");

    // R5 global control
    do_write(A_CTL, 64'h5, 5'h0);
    read_check(A_CTL, "R5 ctl rejects 5");
    do_write(A_CTL, ONES, 5'h0);
    read_check(A_CTL, "R5 ctl ones");
    #1 check("R5 nocap reads zero", {nc_hi, nc_lo}, 64'h0);

    // R6 / R7 banks
    do_write(A_BANK + 15, 64'h0F0F, 5'h0);
    read_check(A_BANK + 15, "R6 last bank");
    do_write(A_BANK + 16, 64'h7777, 5'h0);
    read_check(A_BANK + 16, "R6 past range");
    do_write(A_BANK + 7, 64'h99, 5'h0);
    #1 check("R6 nocap in range", {nc_hi, nc_lo}, 64'h99);
    do_write(A_BANK + 8, 64'h0, 5'h0);
    do_write(A_BANK + 8, ONES, 5'h0);
    #1 check("R6 nocap out of range", {nc_hi, nc_lo}, 64'h0);
    do_write(A_BANK + 4, 64'h5, 5'h0);
    read_check(A_BANK + 4, "R7 offset4 rejects");
    do_write(A_BANK + 5, 64'h5, 5'h0);
    read_check(A_BANK + 5, "R7 offset5 accepts");

    // R8, R9, R10
    do_write(A_CS, 64'hFFFF_FFFF_1234_5678, 5'h0);
    read_check(A_CS, "R8 low16");
    do_write(A_PERF, ONES, 5'h0);
    read_check(A_PERF, "R9 perf const");
    do_write(32'h300, ONES, 5'h1f);
    read_check(32'h300, "R10 unknown zero");

    // R12 same-cycle overlap
    @(negedge clk);
    idx = A_VAR; v = 64'hDEAD_BEEF_0BAD_F00D;
    wr_lo = v[31:0]; wr_hi = v[63:32]; wr_en = 1'b1;
    #1 check("R12 old before edge", {rd_hi, rd_lo}, exp_read(A_VAR));
    @(posedge clk);
    #1 wr_en = 1'b0;
    m_write(A_VAR, v, feat_en);
    check("R12 new after edge", {rd_hi, rd_lo}, exp_read(A_VAR));

    // Random phase
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a;
      logic [4:0] en;
      int unsigned k;
      a = pick_idx($urandom, $urandom);
      en = 5'($urandom);
      k = $urandom % 4;
      v = (k == 0) ? 64'h0 : (k == 1) ? ONES : {$urandom, $urandom};
      @(negedge clk);
      idx = a; wr_lo = v[31:0]; wr_hi = v[63:32]; feat_en = en; wr_en = 1'b1;
      #1 check({"R12 ", tag_of(a)}, {rd_hi, rd_lo}, exp_read(a));
      @(posedge clk);
      #1 wr_en = 1'b0;
      m_write(a, v, en);
      check(tag_of(a), {rd_hi, rd_lo}, exp_read(a));
      read_check(pick_idx($urandom, $urandom), "R10 cross read");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule